// File: doc/BRIEF.md
# JTAG Clock-Enable Synchronizer

This block accepts a debug port whose test clock is unrelated to the system clock and runs the whole test access port inside the system-clock domain. Every register uses the rising edge of `clk` alone. The test clock is never used as a clock. It is sampled like data through a short chain of hardening registers, together with the mode-select and data-in lines. Each transition that survives the chain becomes a one-cycle enable: one for a rising edge and one for a falling edge.

The rising-edge enable advances a 16-state TAP controller and shifts the instruction register or the selected data register. The falling-edge enable launches the next bit on `tdo_out` and commits a new instruction. The synchronized copy of the test clock is returned on `rtck_out`. A debugger that waits for each transition to appear there can never send edges faster than the chain can follow.

The instruction register is 4 bits wide. It selects either a 32-bit identification register or a 1-bit bypass register. Bypass is selected after any reset. The states are TEST_RESET, IDLE, DR_SEL, DR_CAP, DR_SHIFT, DR_EX1, DR_PAUSE, DR_EX2, DR_UPD, IR_SEL, IR_CAP, IR_SHIFT, IR_EX1, IR_PAUSE, IR_EX2 and IR_UPD. Each state steps on the rising-edge enable along the standard TAP diagram, moving on TMS=1 or TMS=0: TEST_RESET→TEST_RESET/IDLE, IDLE→DR_SEL/IDLE, DR_SEL→IR_SEL/DR_CAP, CAP→EX1/SHIFT, SHIFT→EX1/SHIFT, EX1→UPD/PAUSE, PAUSE→EX2/PAUSE, EX2→UPD/SHIFT, UPD→DR_SEL/IDLE, IR_SEL→TEST_RESET/IR_CAP. The instruction-side states follow the same pattern as the data-side states.

Top module: `jtag_ce_sync`

## Requirements
- R1: All registers use the rising edge of `clk`. `tck_in` passes through SYNC_STAGES registers (default 2) before use, and `rtck_out` is that synchronized copy. A level applied just before clock edge k shows on `rtck_out` after edge k+1, so it is visible two clock edges later.
- R2: `tck_rise_en` is high for exactly one cycle: the first cycle in which `rtck_out` reads 1 after reading 0. `tck_fall_en` is the same for the 1→0 change. The two are never high together.
- R3: The TAP controller changes state only in cycles with `tck_rise_en` high. It follows the 16-state diagram above, using the synchronized TMS.
- R4: While `trst_n` is low, it asynchronously clears the synchronizer. `rtck_out`, both enables and `tdo_out` read 0, the controller is forced to TEST_RESET, and bypass is selected.
- R5: Five rising edges with TMS=1 bring the controller to TEST_RESET from any state, and this selects bypass.
- R6: IR_CAP loads the instruction shifter with 4'b0001. The shifter shifts LSB first from `tdi_in` to `tdo_out`.
- R7: Instruction 4'b0010 selects the 32-bit identification register. DR_CAP loads it with IDCODE_VALUE (default 32'h1A5C_E0B3), and it shifts out LSB first. The new instruction takes effect on the falling-edge enable in IR_UPD.
- R8: Every other instruction code, including 4'b1111, selects the 1-bit bypass register. It captures 0 and delays `tdi_in` by one shift.
- R9: `tdo_out` changes only on a falling-edge enable. In IR_SHIFT or DR_SHIFT it launches bit 0 of the active shifter. In all other states it is driven to 0.
- R10: `tms_in` and `tdi_in` pass through the same synchronizer depth as `tck_in`, and they are used only in cycles with the rising-edge enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the only clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tck_in | input | 1 | Test clock from the debugger, treated as data |
| tms_in | input | 1 | Test mode select |
| tdi_in | input | 1 | Test data in |
| rtck_out | output | 1 | Synchronized test clock returned to the debugger |
| tck_rise_en | output | 1 | One-cycle enable per rising test-clock edge |
| tck_fall_en | output | 1 | One-cycle enable per falling test-clock edge |
| tdo_out | output | 1 | Test data out |

## Verification
The bench targets the latency between a test-clock change and `rtck_out`. A chain that is too short or too long breaks the two-edge lag, and doubled or missing enables show up against the per-clock model. It checks the instruction capture pattern and the 32-bit identification readout. An off-by-one shift or a launch on the wrong edge rotates these words. It then pulses `trst_n` in the middle of a data scan and uses a 5×TMS=1 sequence. A design that keeps the old instruction would return the identification bits instead of the one-bit bypass delay. Unknown instruction codes are also scanned, to catch decodes that fail to fall back to bypass.

// File: rtl/jce_pkg.sv
package jce_pkg;

    typedef enum logic [3:0] {
        ST_TEST_RESET,
        ST_IDLE,
        ST_DR_SEL,
        ST_DR_CAP,
        ST_DR_SHIFT,
        ST_DR_EX1,
        ST_DR_PAUSE,
        ST_DR_EX2,
        ST_DR_UPD,
        ST_IR_SEL,
        ST_IR_CAP,
        ST_IR_SHIFT,
        ST_IR_EX1,
        ST_IR_PAUSE,
        ST_IR_EX2,
        ST_IR_UPD
    } tap_state_e;

endpackage

// File: rtl/jce_sync.sv
module jce_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 3
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n) chain[0] <= '0;
                else        chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n) chain[s] <= '0;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/jce_edge.sv
module jce_edge (
    input  logic clk,
    input  logic clr_n,
    input  logic level,
    output logic rise,
    output logic fall
);
    logic level_d;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) level_d <= 1'b0;
        else        level_d <= level;
    end

    assign rise = level & ~level_d;
    assign fall = ~level & level_d;
endmodule

// File: rtl/jce_tap_fsm.sv
module jce_tap_fsm
    import jce_pkg::*;
(
    input  logic       clk,
    input  logic       clr_n,
    input  logic       adv_en,
    input  logic       tms,
    output tap_state_e state
);
    tap_state_e state_nx;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)      state <= ST_TEST_RESET;
        else if (adv_en) state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_TEST_RESET: state_nx = tms ? ST_TEST_RESET : ST_IDLE;
            ST_IDLE:       state_nx = tms ? ST_DR_SEL     : ST_IDLE;
            ST_DR_SEL:     state_nx = tms ? ST_IR_SEL     : ST_DR_CAP;
            ST_DR_CAP:     state_nx = tms ? ST_DR_EX1     : ST_DR_SHIFT;
            ST_DR_SHIFT:   state_nx = tms ? ST_DR_EX1     : ST_DR_SHIFT;
            ST_DR_EX1:     state_nx = tms ? ST_DR_UPD     : ST_DR_PAUSE;
            ST_DR_PAUSE:   state_nx = tms ? ST_DR_EX2     : ST_DR_PAUSE;
            ST_DR_EX2:     state_nx = tms ? ST_DR_UPD     : ST_DR_SHIFT;
            ST_DR_UPD:     state_nx = tms ? ST_DR_SEL     : ST_IDLE;
            ST_IR_SEL:     state_nx = tms ? ST_TEST_RESET : ST_IR_CAP;
            ST_IR_CAP:     state_nx = tms ? ST_IR_EX1     : ST_IR_SHIFT;
            ST_IR_SHIFT:   state_nx = tms ? ST_IR_EX1     : ST_IR_SHIFT;
            ST_IR_EX1:     state_nx = tms ? ST_IR_UPD     : ST_IR_PAUSE;
            ST_IR_PAUSE:   state_nx = tms ? ST_IR_EX2     : ST_IR_PAUSE;
            ST_IR_EX2:     state_nx = tms ? ST_IR_UPD     : ST_IR_SHIFT;
            ST_IR_UPD:     state_nx = tms ? ST_DR_SEL     : ST_IDLE;
        endcase
    end
endmodule

// File: rtl/jtag_ce_sync.sv
module jtag_ce_sync
    import jce_pkg::*;
#(
    parameter int          SYNC_STAGES  = 2,
    parameter int          IR_W         = 4,
    parameter int          ID_W         = 32,
    parameter logic [31:0] IDCODE_VALUE = 32'h1A5C_E0B3,
    parameter logic [3:0]  IDCODE_OP    = 4'b0010
) (
    input  logic clk,
    input  logic trst_n,
    input  logic tck_in,
    input  logic tms_in,
    input  logic tdi_in,
    output logic rtck_out,
    output logic tck_rise_en,
    output logic tck_fall_en,
    output logic tdo_out
);
    localparam logic [IR_W-1:0] BYPASS_OP  = '1;
    localparam logic [IR_W-1:0] IR_CAPTURE = IR_W'(1);
    localparam logic [IR_W-1:0] ID_OP      = IR_W'(IDCODE_OP);
    localparam logic [ID_W-1:0] ID_VAL     = ID_W'(IDCODE_VALUE);

    logic [2:0] sync_q;
    logic       tck_s, tms_s, tdi_s;
    tap_state_e tap_state;

    logic [IR_W-1:0] ir_shift, ir_active;
    logic [ID_W-1:0] id_shift;
    logic            byp_bit;
    logic            id_sel;

    jce_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
        .clk   (clk),
        .clr_n (trst_n),
        .d     ({tck_in, tms_in, tdi_in}),
        .q     (sync_q)
    );

    assign tck_s    = sync_q[2];
    assign tms_s    = sync_q[1];
    assign tdi_s    = sync_q[0];
    assign rtck_out = tck_s;

    jce_edge u_edge (
        .clk   (clk),
        .clr_n (trst_n),
        .level (tck_s),
        .rise  (tck_rise_en),
        .fall  (tck_fall_en)
    );

    jce_tap_fsm u_fsm (
        .clk    (clk),
        .clr_n  (trst_n),
        .adv_en (tck_rise_en),
        .tms    (tms_s),
        .state  (tap_state)
    );

    assign id_sel = (ir_active == ID_OP);

    // Register actions: capture/shift on the rising enable, update/launch on the falling one.
    always_ff @(posedge clk or negedge trst_n) begin
        if (!trst_n) begin
            ir_shift  <= '0;
            ir_active <= BYPASS_OP;
            id_shift  <= '0;
            byp_bit   <= 1'b0;
            tdo_out   <= 1'b0;
        end else begin
            if (tap_state == ST_TEST_RESET) ir_active <= BYPASS_OP;
            if (tck_rise_en) begin
                case (tap_state)
                    ST_IR_CAP:   ir_shift <= IR_CAPTURE;
                    ST_IR_SHIFT: ir_shift <= {tdi_s, ir_shift[IR_W-1:1]};
                    ST_DR_CAP: begin
                        if (id_sel) id_shift <= ID_VAL;
                        byp_bit <= 1'b0;
                    end
                    ST_DR_SHIFT: begin
                        if (id_sel) id_shift <= {tdi_s, id_shift[ID_W-1:1]};
                        else        byp_bit  <= tdi_s;
                    end
                    default: ;
                endcase
            end
            if (tck_fall_en) begin
                if (tap_state == ST_IR_UPD) ir_active <= ir_shift;
                case (tap_state)
                    ST_IR_SHIFT: tdo_out <= ir_shift[0];
                    ST_DR_SHIFT: tdo_out <= id_sel ? id_shift[0] : byp_bit;
                    default:     tdo_out <= 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/jce_checker.sv
module jce_checker
    import jce_pkg::*;
(
    input logic       clk,
    input logic       trst_n,
    input logic       rise,
    input logic       fall,
    input logic       rtck,
    input logic       tdo,
    input tap_state_e state
);
    a_r2_enables_exclusive: assert property (@(posedge clk) disable iff (!trst_n)
        !(rise && fall));

    a_r2_rise_single: assert property (@(posedge clk) disable iff (!trst_n)
        rise |=> !rise);

    a_r2_fall_single: assert property (@(posedge clk) disable iff (!trst_n)
        fall |=> !fall);

    a_r2_rise_follows_rtck: assert property (@(posedge clk) disable iff (!trst_n)
        $rose(rtck) |-> rise);

    a_r3_state_holds: assert property (@(posedge clk) disable iff (!trst_n)
        !rise |=> $stable(state));

    a_r9_tdo_holds: assert property (@(posedge clk) disable iff (!trst_n)
        !fall |=> $stable(tdo));

    a_r9_tdo_quiet: assert property (@(posedge clk) disable iff (!trst_n)
        (fall && state != ST_DR_SHIFT && state != ST_IR_SHIFT) |=> !tdo);
endmodule

bind jtag_ce_sync jce_checker u_chk (
    .clk    (clk),
    .trst_n (trst_n),
    .rise   (tck_rise_en),
    .fall   (tck_fall_en),
    .rtck   (rtck_out),
    .tdo    (tdo_out),
    .state  (tap_state)
);

// File: tb/jtag_ce_sync_tb_top.sv
module jtag_ce_sync_tb_top;
    localparam int          HALF   = 4;
    localparam logic [31:0] ID_EXP = 32'h1A5C_E0B3;

    logic clk = 1'b0;
    logic trst_n = 1'b0;
    logic tck_in = 1'b0, tms_in = 1'b1, tdi_in = 1'b0;
    logic rtck_out, tck_rise_en, tck_fall_en, tdo_out;

    int  checks = 0, errors = 0;
    bit  done = 1'b0;
    bit  model_on = 1'b0;
    logic [2:0] hist = '0;

    always #4 clk = ~clk;

    jtag_ce_sync dut_i (
        .clk(clk), .trst_n(trst_n), .tck_in(tck_in), .tms_in(tms_in),
        .tdi_in(tdi_in), .rtck_out(rtck_out), .tck_rise_en(tck_rise_en),
        .tck_fall_en(tck_fall_en), .tdo_out(tdo_out)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference history of sampled tck: [0] first stage, [1] returned clock, [2] previous.
    always @(posedge clk or negedge trst_n) begin
        if (!trst_n) hist = '0;
        else         hist = {hist[1:0], tck_in};
    end

    always @(negedge clk) begin
        if (model_on) begin
            chk(rtck_out === hist[1], "R1", "rtck lag", rtck_out, hist[1]);
            chk(tck_rise_en === (hist[1] & ~hist[2]), "R2", "rise enable",
                tck_rise_en, hist[1] & ~hist[2]);
            chk(tck_fall_en === (~hist[1] & hist[2]), "R2", "fall enable",
                tck_fall_en, ~hist[1] & hist[2]);
        end
    end

    task automatic tick(input bit tms, input bit tdi, output bit tdo_seen);
        int n;
        tms_in = tms;
        tdi_in = tdi;
        tdo_seen = tdo_out;
        tck_in = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (rtck_out !== 1'b1 && n < 20);
        chk(n == 2, "R1", "rtck rise latency", n, 2);
        repeat (HALF - n) @(negedge clk);
        tck_in = 1'b0;
        n = 0;
        do begin @(negedge clk); n++; end while (rtck_out !== 1'b0 && n < 20);
        chk(n == 2, "R1", "rtck fall latency", n, 2);
        repeat (HALF - n) @(negedge clk);
    endtask

    task automatic go_idle();
        bit b;
        repeat (5) tick(1'b1, 1'b0, b);
        tick(1'b0, 1'b0, b);
    endtask

    task automatic scan_ir(input logic [3:0] code, output logic [3:0] cap);
        bit b;
        tick(1'b1, 1'b0, b); tick(1'b1, 1'b0, b);
        tick(1'b0, 1'b0, b); tick(1'b0, 1'b0, b);
        for (int i = 0; i < 4; i++) begin
            tick(i == 3, code[i], b);
            cap[i] = b;
        end
        tick(1'b1, 1'b0, b); tick(1'b0, 1'b0, b);
    endtask

    task automatic scan_dr(input int len, input logic [31:0] din, output logic [31:0] dout);
        bit b;
        dout = '0;
        tick(1'b1, 1'b0, b); tick(1'b0, 1'b0, b); tick(1'b0, 1'b0, b);
        for (int i = 0; i < len; i++) begin
            tick(i == len - 1, din[i], b);
            dout[i] = b;
        end
        tick(1'b1, 1'b0, b); tick(1'b0, 1'b0, b);
    endtask

    initial begin
        logic [3:0]  cap;
        logic [31:0] dout;
        bit b;
        repeat (3) @(negedge clk);
        model_on = 1'b1;
        // R4: reset state
        chk(rtck_out === 1'b0, "R4", "rtck in reset", rtck_out, 0);
        chk(tdo_out === 1'b0, "R4", "tdo in reset", tdo_out, 0);
        chk({tck_rise_en, tck_fall_en} === 2'b00, "R4", "enables in reset",
            {tck_rise_en, tck_fall_en}, 0);
        trst_n = 1'b1;
        repeat (2) @(negedge clk);
        go_idle();
        chk(tdo_out === 1'b0, "R9", "tdo in IDLE", tdo_out, 0);

        // R8 R10: bypass after reset delays tdi by one bit, captured 0
        scan_dr(8, 32'hA5, dout);
        chk(dout[7:0] === 8'h4A, "R8", "bypass R10 tdi path", dout[7:0], 8'h4A);

        // R6 R3: capture pattern while walking to IR shift
        scan_ir(4'b0010, cap);
        chk(cap === 4'b0001, "R6", "IR capture R3", cap, 4'b0001);

        // R7: identification readout
        scan_dr(32, 32'h0, dout);
        chk(dout === ID_EXP, "R7", "idcode scan", dout, ID_EXP);
        scan_dr(32, 32'hFFFF_0000, dout);
        chk(dout === ID_EXP, "R7", "idcode recapture", dout, ID_EXP);

        // R5: five TMS=1 reach reset and select bypass
        go_idle();
        scan_dr(8, 32'h3C, dout);
        chk(dout[7:0] === 8'h78, "R5", "bypass after TMS reset", dout[7:0], 8'h78);

        // R8: unknown code falls back to bypass
        scan_ir(4'b0101, cap);
        scan_dr(8, 32'h81, dout);
        chk(dout[7:0] === 8'h02, "R8", "unknown code bypass", dout[7:0], 8'h02);

        // R4: reset during a data scan
        scan_ir(4'b0010, cap);
        tick(1'b1, 1'b0, b); tick(1'b0, 1'b0, b); tick(1'b0, 1'b0, b);
        tick(1'b0, 1'b0, b); tick(1'b0, 1'b0, b);
        trst_n = 1'b0;
        @(negedge clk);
        chk(rtck_out === 1'b0, "R4", "rtck after trst", rtck_out, 0);
        chk(tdo_out === 1'b0, "R4", "tdo after trst", tdo_out, 0);
        repeat (2) @(negedge clk);
        trst_n = 1'b1;
        repeat (2) @(negedge clk);
        tick(1'b0, 1'b0, b);
        scan_dr(8, 32'hC3, dout);
        chk(dout[7:0] === 8'h86, "R4", "bypass after trst", dout[7:0], 8'h86);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule